// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous request port and an external 128K x 8 asynchronous static RAM. It turns one read or one write at a time into a timed sequence of strobes. The RAM is selected only when its active-low enable is low and its active-high enable is high. It also has an active-low write strobe, an active-low output enable and a shared data bus. The shared bus is brought out here as a separate output value, an output-enable and an input value, so that a pad ring can join them.

Requests arrive on a valid/ready handshake with a 17-bit address, a data byte and a direction flag. A read returns its byte together with a one-cycle valid pulse. Every strobe width is a whole number of system clocks. The controller computes these counts at elaboration time from the clock period, given in picoseconds, and from a speed-grade switch (35 ns or 55 ns part). Each minimum time is rounded up to the next whole cycle.

Between requests the RAM is deselected, so it stays in standby. After a read, the controller waits for the RAM's output-disable time to pass before it takes another request. This keeps its own bus driver from overlapping the RAM's output.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, the controller raises `req_ready`, parks the RAM deselected (`ram_sel_n`=1, `ram_sel`=0), keeps `ram_wr_n`=1 and `ram_rd_n`=1, and turns its bus driver off (`ram_dq_oe`=0). The two enables always take opposite levels.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its address appears on `ram_addr` from the next cycle and does not change while the RAM is selected.
- R3: A read selects the RAM with `ram_rd_n`=0 and `ram_wr_n`=1 for RA+1 cycles. RA is the larger of ceil(address access / T) and ceil(output-enable access / T). The access times are 35/15 ns on the fast grade and 55/25 ns on the slow grade, and T is the clock period.
- R4: `rd_data` takes `ram_dq_in` on the edge that ends the last selected read cycle. `rd_valid` is high for exactly the one following cycle.
- R5: After a read, the RAM stays deselected with `ram_rd_n`=1 and the driver off for max(1, ceil(output-disable / T)) cycles before `req_ready` returns. Output-disable is 12 ns (fast) or 15 ns (slow).
- R6: A write first spends one cycle with the RAM selected, `ram_wr_n`=1 and `ram_rd_n`=1.
- R7: `ram_wr_n` then stays low for WP cycles, where WP = max(ceil(write pulse / T), ceil(data setup / T)). These are 20/15 ns on the fast grade and 35/25 ns on the slow grade. During those cycles `ram_dq_out` carries the request's data and `ram_dq_oe`=1.
- R8: After the write pulse, the RAM is deselected for max(1, ceil(cycle time / T) - 1 - WP) cycles. Cycle time is 35 ns or 55 ns. The driver stays on, with the same data, during only the first of those cycles.
- R9: `ram_rd_n` is never low while `ram_wr_n` is low or while `ram_dq_oe` is high.
- R10: All cycle counts are integer ceilings of picoseconds divided by `CLK_PS`, taken at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` is new |
| rd_data | output | 8 | Last byte read |
| ram_addr | output | 17 | RAM address pins |
| ram_sel_n | output | 1 | RAM active-low enable |
| ram_sel | output | 1 | RAM active-high enable |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_rd_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Value driven onto the data pins |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | 8 | Value sensed on the data pins |

## Verification
Two things can fall in the same cycle. One is the controller's own write driver turning on. The other is the RAM still holding the shared bus after a read has dropped its output enable. The bench provokes this by keeping `req_valid` high through read-then-write and write-then-read pairs, so each new request is taken on the first cycle the controller is idle again. The bench's RAM model treats the bus as busy for its own computed output-disable window after a drive. Any cycle in which the controller drives while the RAM may still drive is judged a failure.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACC = 3'd1,
    ST_RD_CAP = 3'd2,
    ST_WR_SET = 3'd3,
    ST_WR_PUL = 3'd4,
    ST_RECOV  = 3'd5
  } sramc_state_e;

  function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // read access: both address and output-enable access limits must pass
  function automatic int unsigned rd_access_cyc(input bit fast, input int unsigned clk_ps);
    int unsigned t_addr, t_oe;
    t_addr = fast ? 35000 : 55000;
    t_oe   = fast ? 15000 : 25000;
    return imax(1, imax(ps_to_cyc(t_addr, clk_ps), ps_to_cyc(t_oe, clk_ps)));
  endfunction

  // time the RAM may keep driving after output enable rises
  function automatic int unsigned rd_recover_cyc(input bit fast, input int unsigned clk_ps);
    return imax(1, ps_to_cyc(fast ? 12000 : 15000, clk_ps));
  endfunction

  function automatic int unsigned wr_pulse_cyc(input bit fast, input int unsigned clk_ps);
    int unsigned t_wp, t_ds;
    t_wp = fast ? 20000 : 35000;
    t_ds = fast ? 15000 : 25000;
    return imax(1, imax(ps_to_cyc(t_wp, clk_ps), ps_to_cyc(t_ds, clk_ps)));
  endfunction

  // remainder of the write cycle after one setup cycle and the pulse
  function automatic int unsigned wr_recover_cyc(input bit fast, input int unsigned clk_ps);
    int unsigned t_wc, wp;
    t_wc = ps_to_cyc(fast ? 35000 : 55000, clk_ps);
    wp   = wr_pulse_cyc(fast, clk_ps);
    return (t_wc > wp + 2) ? (t_wc - 1 - wp) : 1;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_timer_counts_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_LEN = 5,
  parameter int RR_LEN = 2,
  parameter int WP_LEN = 3,
  parameter int WR_LEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_expired,
  output sramc_state_e  state,
  output logic          accept,
  output logic          capture,
  output logic          wr_guard,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  localparam logic [CW-1:0] LD_RD  = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] LD_RR  = CW'(RR_LEN - 1);
  localparam logic [CW-1:0] LD_WP  = CW'(WP_LEN - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(WR_LEN - 1);

  sramc_state_e state_q, state_d;
  logic         guard_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        state_d  = req_write ? ST_WR_SET : ST_RD_ACC;
        tmr_val  = req_write ? '0 : LD_RD;
      end
      ST_RD_ACC: if (tmr_expired) state_d = ST_RD_CAP;
      ST_RD_CAP: begin
        capture  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LD_RR;
        state_d  = ST_RECOV;
      end
      ST_WR_SET: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = LD_WP;
        state_d  = ST_WR_PUL;
      end
      ST_WR_PUL: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = LD_WR;
        state_d  = ST_RECOV;
      end
      ST_RECOV: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      guard_q <= 1'b0;
    end else begin
      state_q <= state_d;
      guard_q <= (state_q == ST_WR_PUL) && (state_d == ST_RECOV);
    end
  end

  assign state    = state_q;
  assign wr_guard = guard_q;

  p_guard_in_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q |-> (state_q == ST_RECOV));
  p_guard_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    guard_q |=> !guard_q);
endmodule

// File: rtl/sramc_io.sv
module sramc_io
  import sramc_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sramc_state_e  state,
  input  logic          accept,
  input  logic          capture,
  input  logic          wr_guard,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ram_dq_in,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_wr_n,
  output logic          ram_rd_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;
  logic          selected, reading, pulsing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= ram_dq_in;
      rvalid_q <= capture;
    end
  end

  assign selected = (state == ST_RD_ACC) || (state == ST_RD_CAP) ||
                    (state == ST_WR_SET) || (state == ST_WR_PUL);
  assign reading  = (state == ST_RD_ACC) || (state == ST_RD_CAP);
  assign pulsing  = (state == ST_WR_PUL);

  assign ram_addr   = addr_q;
  assign ram_sel_n  = !selected;
  assign ram_sel    = selected;
  assign ram_wr_n   = !pulsing;
  assign ram_rd_n   = !reading;
  assign ram_dq_out = wdata_q;
  assign ram_dq_oe  = pulsing || wr_guard;
  assign rd_valid   = rvalid_q;
  assign rd_data    = rdata_q;

  p_rdv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_no_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_rd_n));
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_wr_n && !ram_rd_n));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && $past(!ram_sel_n)) |-> $stable(ram_addr));
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_PS = 8000,
  parameter bit FAST   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_wr_n,
  output logic          ram_rd_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);
  localparam int RD_LEN = int'(rd_access_cyc(FAST, CLK_PS));
  localparam int RR_LEN = int'(rd_recover_cyc(FAST, CLK_PS));
  localparam int WP_LEN = int'(wr_pulse_cyc(FAST, CLK_PS));
  localparam int WR_LEN = int'(wr_recover_cyc(FAST, CLK_PS));
  localparam int MAXLEN = int'(imax(imax(RD_LEN, RR_LEN), imax(WP_LEN, WR_LEN)));
  localparam int CW     = $clog2(MAXLEN + 1);

  sramc_state_e  state;
  logic          accept, capture, wr_guard, tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  sramc_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sramc_fsm #(
    .CW(CW), .RD_LEN(RD_LEN), .RR_LEN(RR_LEN), .WP_LEN(WP_LEN), .WR_LEN(WR_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_expired(tmr_expired), .state(state), .accept(accept), .capture(capture),
    .wr_guard(wr_guard), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sramc_io #(.AW(AW), .DW(DW)) u_io (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(accept), .capture(capture),
    .wr_guard(wr_guard), .req_addr(req_addr), .req_wdata(req_wdata),
    .ram_dq_in(ram_dq_in), .ram_addr(ram_addr), .ram_sel_n(ram_sel_n),
    .ram_sel(ram_sel), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  assign req_ready = (state == ST_IDLE);

  // run length of the write strobe, for the width check below
  int unsigned we_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run_q <= 0;
    else if (!ram_wr_n) we_run_q <= we_run_q + 1;
    else                we_run_q <= 0;
  end

  p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_sel_n && !ram_sel && ram_wr_n && ram_rd_n && !ram_dq_oe));
  p_enables_paired_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel_n != ram_sel);
  p_we_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ram_wr_n) && ram_wr_n) |-> (we_run_q >= WP_LEN));
  p_setup_before_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_wr_n) |-> $past(!ram_sel_n));
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int T_PS = 8000;

  function automatic int cyc(input int ns);
    return (ns * 1000 + T_PS - 1) / T_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  // own restatement of the fast-grade counts
  localparam int B_RD = 5;  // max(ceil(35/8), ceil(15/8))
  localparam int B_RR = 2;  // ceil(12/8)
  localparam int B_WP = 3;  // max(ceil(20/8), ceil(15/8))
  localparam int B_WR = 1;  // max(1, ceil(35/8)-1-3)

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_dq_oe;
  logic [7:0] rd_data, ram_dq_out, ram_dq_in;
  logic [16:0] ram_addr;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_wr_n(ram_wr_n),
    .ram_rd_n(ram_rd_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  // behavioural RAM
  logic [7:0] mem [int];
  logic ram_drv;
  int   bus_tail = 0;
  assign ram_drv   = !ram_sel_n && ram_sel && ram_wr_n && !ram_rd_n;
  assign ram_dq_in = ram_drv ? (mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h5A) : 8'hEE;

  int total = 0, bad = 0, cycles = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected per-cycle {sel_n, sel, wr_n, rd_n, dq_oe, rdv} with a phase code
  typedef struct packed { logic [5:0] v; logic [2:0] ph; } exp_t;
  exp_t q[$];
  logic [16:0] exp_addr;
  logic [7:0]  exp_wdata, exp_rdata;

  function automatic string ph_tag(input logic [2:0] p);
    case (p)
      3'd1: return "R3 read strobes";
      3'd2: return "R5 read recovery";
      3'd3: return "R6 write setup";
      3'd4: return "R7 write pulse";
      3'd5: return "R8 write recovery";
      default: return "R1 idle";
    endcase
  endfunction

  always @(posedge clk) begin
    bit was_empty;
    if (rst_n) begin
      cycles++;
      if (ram_drv) bus_tail = cyc(12);
      else if (bus_tail > 0) bus_tail--;
      was_empty = (q.size() == 0);
      if (!was_empty) void'(q.pop_front());
      if (was_empty && req_valid) begin
        exp_addr  = req_addr;
        exp_wdata = req_wdata;
        if (!req_write) begin
          exp_rdata = mem.exists(int'(req_addr)) ? mem[int'(req_addr)] : 8'h5A;
          for (int i = 0; i < B_RD + 1; i++) q.push_back('{6'b011000, 3'd1});
          for (int i = 0; i < B_RR; i++) q.push_back('{(i == 0) ? 6'b101101 : 6'b101100, 3'd2});
        end else begin
          q.push_back('{6'b011100, 3'd3});
          for (int i = 0; i < B_WP; i++) q.push_back('{6'b010110, 3'd4});
          for (int i = 0; i < B_WR; i++) q.push_back('{(i == 0) ? 6'b101110 : 6'b101100, 3'd5});
        end
      end
    end
  end

  // per-cycle comparison away from the edge
  logic prev_wr_n = 1, prev_rd_n = 1;
  int   wlo = 0, rlo = 0;
  always @(negedge clk) begin
    exp_t e;
    logic [5:0] act;
    #1;
    if (rst_n) begin
      e   = (q.size() > 0) ? q[0] : '{6'b101100, 3'd0};
      act = {ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_dq_oe, rd_valid};
      check(act == e.v, ph_tag(e.ph), int'(act), int'(e.v));
      check(req_ready == (q.size() == 0), "R1 ready only when idle", int'(req_ready), int'(q.size() == 0));
      if (!ram_sel_n) check(ram_addr == exp_addr, "R2 address held", int'(ram_addr), int'(exp_addr));
      if (ram_dq_oe) begin
        check(ram_dq_out == exp_wdata, "R7 write data", int'(ram_dq_out), int'(exp_wdata));
        check(!ram_drv && bus_tail == 0, "R9 bus contention", bus_tail, 0);
      end
      if (e.v[0]) check(rd_data == exp_rdata, "R4 read data", int'(rd_data), int'(exp_rdata));
      // write commits when the strobe rises with data still driven (guard cycle)
      if (!prev_wr_n && ram_wr_n && ram_dq_oe) mem[int'(ram_addr)] = ram_dq_out;
      if (!ram_wr_n) wlo++;
      else if (!prev_wr_n) begin
        check(wlo == mx(cyc(20), cyc(15)), "R10 pulse count", wlo, mx(cyc(20), cyc(15)));
        wlo = 0;
      end
      if (!ram_rd_n) rlo++;
      else if (!prev_rd_n) begin
        check(rlo == mx(cyc(35), cyc(15)) + 1, "R10 read count", rlo, mx(cyc(35), cyc(15)) + 1);
        rlo = 0;
      end
      prev_wr_n = ram_wr_n;
      prev_rd_n = ram_rd_n;
    end
  end

  // called at a negative edge; returns at the negative edge after acceptance
  task automatic xfer(input bit wr, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    req_addr  = ~a;
    req_wdata = ~d;
  endtask

  task automatic drain();
    while (q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ram_sel_n && !ram_sel && ram_wr_n && ram_rd_n && !ram_dq_oe && !rd_valid,
          "R1 reset parked", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    // separated writes and reads
    xfer(1, 17'h00000, 8'hA5); drain();
    xfer(1, 17'h1FFFF, 8'h3C); drain();
    xfer(0, 17'h00000, 8'h00); drain();
    xfer(0, 17'h1FFFF, 8'h00); drain();
    xfer(0, 17'h0ABCD, 8'h00); drain();   // never written: model default
    // back-to-back: write then read of same word, read then write (R9 window)
    xfer(1, 17'h0AAAA, 8'h81);
    xfer(0, 17'h0AAAA, 8'h00);
    xfer(1, 17'h15555, 8'h7E);
    xfer(0, 17'h15555, 8'h00);
    xfer(0, 17'h00000, 8'h00);
    xfer(1, 17'h00000, 8'hFF);
    xfer(0, 17'h00000, 8'h00);
    drain();
    // walking pattern
    for (int i = 0; i < 17; i++) xfer(1, 17'(1 << i), 8'(i * 13 + 1));
    for (int i = 0; i < 17; i++) xfer(0, 17'(1 << i), 8'h00);
    drain();
    // request held off mid-transfer: valid raised during busy
    xfer(1, 17'h01234, 8'h42);
    repeat (2) @(negedge clk);
    xfer(0, 17'h01234, 8'h00);
    drain();
    check(mem[int'(17'h01234)] == 8'h42, "R7 written byte stored", int'(mem[int'(17'h01234)]), 8'h42);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule